// File: doc/BRIEF.md
# Two-Wire Debug Register Master

This block is the host end of a two-wire debug link: one clock line it drives and one data line shared with the target. A user-side pulse on `start_i` with a 7-bit register address, a direction flag and 32 bits of write data sends one complete register access frame. When the frame is over, `done_o` pulses, `rdata_o` holds the word read back and `perr_o` flags a bad data parity.

Each frame is 52 bit slots long, and each slot is one period of the link clock. The master places or releases data while the clock is low. It samples the line on the rising edge. The clock half-period is `div_i + 1` system clocks. The value of `div_i` is captured when a frame starts, so the rate can change between frames but not during one.

Slot layout, by slot number:
- 0–6: address.
- 7: direction bit.
- 8: header parity.
- 9–11: three released turnaround slots.
- 12–13: two fixed zeros.
- 14–45: 32 data bits.
- 46: data parity.
- 47–49: three more released slots.
- 50–51: a closing one and then a zero.

Top module: `twd_master`

## Requirements
- R1: Slots 0–6 drive the address, most-significant bit first. Slot 7 drives the direction bit: 1 for write, 0 for read.
- R2: Slot 8 drives an even-parity bit over the 7 address bits and the direction bit. The count of ones across those 9 bits is even.
- R3: In slots 9–11 and 47–49 the drive enable is low and the data output is 0. The input line is ignored there: its value has no effect on `rdata_o`, `perr_o` or any driven slot.
- R4: Slots 12 and 13 are driven 0. Slot 50 is driven 1 and slot 51 is driven 0. This holds for both reads and writes.
- R5: In a write, slots 14–45 drive `wdata_i`, most-significant bit first. Slot 46 drives the even-parity bit over those 32 bits.
- R6: In a read, slots 14–46 are released: enable low, output 0.
  - The 32 values sampled in slots 14–45 appear MSB-first in `rdata_o`.
  - `perr_o` is 1 exactly when the 32 sampled data bits plus the bit sampled in slot 46 hold an odd count of ones.
  - `perr_o` is cleared when a frame starts.
  - A write leaves `rdata_o` unchanged.
- R7: Each slot is a low half followed by a high half of `swclk_o`, each half `div_i + 1` system clocks long. So successive rising edges are `2*(div_i+1)` cycles apart. The data output and the drive enable change only while `swclk_o` is low. When idle, `swclk_o` and the enable are low.
- R8: `done_o` is a one-cycle pulse after the high half of slot 51. Exactly 52 rising clock edges occur per frame. A `start_i` seen while a frame is running is ignored.
- R9: After reset the block is idle with `swclk_o`, `swd_oe_o`, `swd_do_o`, `done_o`, `perr_o` at 0 and `rdata_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (accepted only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Debug register address |
| wdata_i | input | 32 | Write data |
| div_i | input | DIV_W | Half-period of the link clock minus one, in system clocks |
| rdata_o | output | 32 | Last word read from the target |
| perr_o | output | 1 | Read data parity mismatch |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| swclk_o | output | 1 | Link clock |
| swd_oe_o | output | 1 | Data line drive enable |
| swd_do_o | output | 1 | Data line output value |
| swd_di_i | input | 1 | Data line input value |

## Verification
The bench records the drive enable and output at every rising link clock edge. It compares the whole 52-slot record with a frame it builds by concatenation, across all directions, four clock dividers and addresses that include all-zeros and all-ones.

It feeds noise into every slot the master does not read. A design that sampled a turnaround slot, or shifted one slot too early or late, would then show a corrupted `rdata_o` or a false parity error. It also injects deliberate parity faults to prove that the error flag follows the sampled parity bit and not the local one.

It measures the spacing of rising edges against the divider, and it retriggers `start_i` in the middle of a frame. A design that restarted the frame or emitted a second frame would show extra edges or a second `done_o` pulse.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  // slot positions inside a frame; the order is the protocol itself
  localparam int S_DIR  = ADDR_W;
  localparam int S_HPAR = S_DIR + 1;
  localparam int S_TA0  = S_HPAR + 1;
  localparam int S_Z0   = S_TA0 + 3;
  localparam int S_DAT  = S_Z0 + 2;
  localparam int S_DPAR = S_DAT + DATA_W;
  localparam int S_TB0  = S_DPAR + 1;
  localparam int S_ONE  = S_TB0 + 3;
  localparam int S_END  = S_ONE + 1;
  localparam int N_SLOT = S_END + 1;
  localparam int IDX_W  = $clog2(N_SLOT);

  typedef enum logic [1:0] {K_DRV, K_IGN, K_RDAT, K_RPAR} slot_kind_e;

  function automatic logic hdr_par(input logic [ADDR_W-1:0] a, input logic w);
    return ^{a, w};
  endfunction

  function automatic logic data_par(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  function automatic slot_kind_e slot_kind(input logic [IDX_W-1:0] idx, input logic w);
    int i;
    i = int'(idx);
    if (i < S_TA0)       return K_DRV;
    else if (i < S_Z0)   return K_IGN;
    else if (i < S_DAT)  return K_DRV;
    else if (i < S_DPAR) return w ? K_DRV : K_RDAT;
    else if (i == S_DPAR) return w ? K_DRV : K_RPAR;
    else if (i < S_ONE)  return K_IGN;
    else                 return K_DRV;
  endfunction

  function automatic logic slot_bit(input logic [IDX_W-1:0] idx,
                                    input logic [ADDR_W-1:0] a, input logic w,
                                    input logic [DATA_W-1:0] d);
    int i;
    logic [ADDR_W-1:0] ta;
    logic [DATA_W-1:0] td;
    i  = int'(idx);
    ta = a >> (ADDR_W - 1 - i);
    td = d >> (DATA_W - 1 - (i - S_DAT));
    if (i < S_DIR)        return ta[0];
    else if (i == S_DIR)  return w;
    else if (i == S_HPAR) return hdr_par(a, w);
    else if (i < S_DAT)   return 1'b0;
    else if (i < S_DPAR)  return td[0];
    else if (i == S_DPAR) return data_par(d);
    else if (i == S_ONE)  return 1'b1;
    else                  return 1'b0;
  endfunction
endpackage

// File: rtl/twd_divider.sv
module twd_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> cnt <= limit);
endmodule

// File: rtl/twd_framer.sv
module twd_framer
  import twd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tick,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             phase,
  output logic             rise,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(S_END);

  assign rise = busy && tick && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; phase <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy <= 1'b1; idx <= '0; phase <= 1'b0;
        end
      end else if (tick) begin
        if (!phase) begin
          phase <= 1'b1;
        end else if (idx == LAST) begin
          busy <= 1'b0; phase <= 1'b0; done <= 1'b1;
        end else begin
          idx <= idx + 1'b1; phase <= 1'b0;
        end
      end
    end
  end

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) idx <= LAST);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !phase);
endmodule

// File: rtl/twd_rx.sv
module twd_rx
  import twd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rise,
  input  slot_kind_e        kind,
  input  logic              din,
  input  logic              line_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              perr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; perr <= 1'b0;
    end else if (accept) begin
      perr <= 1'b0;
    end else if (rise && kind == K_RDAT) begin
      rdata <= {rdata[DATA_W-2:0], din};
    end else if (rise && kind == K_RPAR) begin
      perr <= data_par(rdata) ^ din;
    end
  end

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && (kind == K_RDAT || kind == K_RPAR) |-> !line_oe);
endmodule

// File: rtl/twd_master.sv
module twd_master
  import twd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              perr_o,
  output logic              done_o,
  output logic              swclk_o,
  output logic              swd_oe_o,
  output logic              swd_do_o,
  input  logic              swd_di_i
);
  logic              busy, rise, tick, accept;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DIV_W-1:0]  div_q;
  slot_kind_e        kind;

  assign accept = start_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; wr_q <= 1'b0; wdata_q <= '0; div_q <= '0;
    end else if (accept) begin
      addr_q <= addr_i; wr_q <= wr_i; wdata_q <= wdata_i; div_q <= div_i;
    end
  end

  twd_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .limit(div_q), .tick(tick)
  );

  twd_framer u_frm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .tick(tick),
    .busy(busy), .idx(idx), .phase(swclk_o), .rise(rise), .done(done_o)
  );

  assign kind     = slot_kind(idx, wr_q);
  assign swd_oe_o = busy && (kind == K_DRV);
  assign swd_do_o = swd_oe_o && slot_bit(idx, addr_q, wr_q, wdata_q);

  twd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rise(rise), .kind(kind),
    .din(swd_di_i), .line_oe(swd_oe_o), .rdata(rdata_o), .perr(perr_o)
  );

  // R7
  stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swclk_o && $past(swclk_o) |-> $stable(swd_do_o) && $stable(swd_oe_o));
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk_o && !swd_oe_o);
endmodule

// File: tb/test_twd_master.sv
module test_twd_master;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  div = '0;
  logic [31:0] rdata;
  logic        perr, done, swclk, oe, dout, din;

  int tests = 0, fails = 0;
  int slotcnt = 0, done_cnt = 0;
  logic [51:0] seen_oe, seen_do, resp;
  time t_r0, t_r1;
  logic [31:0] last_rd = 32'h0;

  always #10 clk = ~clk;

  twd_master i_twd_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .div_i(div), .rdata_o(rdata), .perr_o(perr), .done_o(done),
    .swclk_o(swclk), .swd_oe_o(oe), .swd_do_o(dout), .swd_di_i(din)
  );

  assign din = (slotcnt < 52) ? resp[51 - slotcnt] : 1'b0;

  always @(posedge swclk) begin
    if (slotcnt < 52) begin
      seen_oe[51 - slotcnt] = oe;
      seen_do[51 - slotcnt] = dout;
    end
    if (slotcnt == 0) t_r0 = $time;
    if (slotcnt == 1) t_r1 = $time;
    slotcnt = slotcnt + 1;
  end

  always @(posedge clk) if (done) done_cnt = done_cnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [6:0] a, input logic w, input logic [31:0] wd,
                         input logic [31:0] rv, input logic bad, input logic [7:0] dv,
                         input logic [31:0] seed, input bit retrig);
    logic [51:0] ex_oe, ex_do;
    logic hp, dp, rp;
    hp = ($countones({a, w}) % 2) == 1;
    dp = ($countones(wd) % 2) == 1;
    rp = ($countones(rv) % 2) == 1;
    ex_oe = {7'h7f, 1'b1, 1'b1, 3'b000, 2'b11, (w ? 32'hFFFF_FFFF : 32'h0), w, 3'b000, 2'b11};
    ex_do = {a, w, hp, 3'b000, 2'b00, (w ? wd : 32'h0), (w & dp), 3'b000, 2'b10};
    resp = {seed, seed[31:12] ^ 20'hA5C3B};
    if (!w) begin
      resp[37:6] = rv;
      resp[5]    = rp ^ bad;
    end
    @(negedge clk);
    div = dv; addr = a; wr = w; wdata = wd;
    slotcnt = 0; done_cnt = 0; seen_oe = '0; seen_do = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (retrig) begin
      repeat (30) @(negedge clk);
      addr = ~a; wr = ~w; wdata = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    // R1 address MSB first, then direction
    chk({seen_oe[51:44], seen_do[51:44]} == {ex_oe[51:44], ex_do[51:44]}, "R1 header",
        {seen_oe[51:44], seen_do[51:44]}, {ex_oe[51:44], ex_do[51:44]});
    // R2 header parity
    chk({seen_oe[43], seen_do[43]} == {ex_oe[43], ex_do[43]}, "R2 header parity",
        {seen_oe[43], seen_do[43]}, {ex_oe[43], ex_do[43]});
    // R3 released slots
    chk({seen_oe[42:40], seen_do[42:40], seen_oe[4:2], seen_do[4:2]} == 12'h0, "R3 released slots",
        {seen_oe[42:40], seen_do[42:40], seen_oe[4:2], seen_do[4:2]}, 0);
    // R4 fixed bits
    chk({seen_oe[39:38], seen_do[39:38], seen_oe[1:0], seen_do[1:0]} == 8'b11_00_11_10, "R4 fixed bits",
        {seen_oe[39:38], seen_do[39:38], seen_oe[1:0], seen_do[1:0]}, 8'b11_00_11_10);
    if (w) begin
      // R5 write data and parity
      chk({seen_oe[37:5], seen_do[37:5]} == {ex_oe[37:5], ex_do[37:5]}, "R5 write data",
          {seen_oe[37:5], seen_do[37:5]}, {ex_oe[37:5], ex_do[37:5]});
      // R6 write leaves read data alone
      chk(rdata == last_rd, "R6 rdata kept on write", rdata, last_rd);
      chk(perr == 1'b0, "R6 perr on write", perr, 0);
    end else begin
      // R6 read slots released, data and parity flag
      chk({seen_oe[37:5], seen_do[37:5]} == 66'h0, "R6 read release",
          {seen_oe[37:5], seen_do[37:5]}, 0);
      chk(rdata == rv, "R6 rdata", rdata, rv);
      chk(perr == bad, "R6 perr", perr, bad);
      last_rd = rv;
    end
    // R7 clock period from divider
    chk((t_r1 - t_r0) == time'(40 * (int'(dv) + 1)), "R7 clock period", t_r1 - t_r0, 40 * (int'(dv) + 1));
    repeat (2 * (int'(dv) + 1) * 4 + 6) @(negedge clk);
    // R7 idle after frame; R8 one frame, one strobe
    chk(!swclk && !oe, "R7 idle lines", {swclk, oe}, 0);
    chk(slotcnt == 52 && done_cnt == 1, "R8 edges and done count", {slotcnt, done_cnt}, {32'd52, 32'd1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [6:0] alist [4];
    alist[0] = 7'h00; alist[1] = 7'h7F; alist[2] = 7'h2A; alist[3] = 7'h16;
    resp = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({swclk, oe, dout, done, perr} == 5'b0 && rdata == 32'h0, "R9 reset state",
        {swclk, oe, dout, done, perr, rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int dv = 0; dv < 4; dv++) begin
      for (int ai = 0; ai < 4; ai++) begin
        logic [31:0] pat;
        pat = (32'h1 << (ai * 9 + dv)) ^ (32'h9E37_79B9 * (ai + 4 * dv + 1));
        run_txn(alist[ai], 1'b1, pat, 32'h0, 1'b0, 8'(dv), pat ^ 32'h5A5A_0F0F, 1'b0);
        run_txn(alist[ai], 1'b0, 32'h0, ~pat, (ai == 2), 8'(dv), pat * 3, 1'b0);
      end
    end
    run_txn(7'h11, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, 8'd1, 32'hFFFF_FFFF, 1'b0);
    run_txn(7'h11, 1'b0, 32'h0, 32'h0000_0000, 1'b1, 8'd0, 32'hFFFF_FFFF, 1'b0);
    run_txn(7'h12, 1'b0, 32'h0, 32'h8000_0001, 1'b1, 8'd2, 32'h0, 1'b0);
    // R8 retrigger during a frame is ignored
    run_txn(7'h35, 1'b1, 32'hC0DE_F00D, 32'h0, 1'b0, 8'd1, 32'h1234_5678, 1'b1);
    run_txn(7'h4C, 1'b0, 32'h0, 32'h0BAD_CAFE, 1'b0, 8'd2, 32'h8765_4321, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule